// File: doc/BRIEF.md
# Flattened-Carry Four-Bit Adder

This block adds two 4-bit operands and a carry input, producing a 4-bit sum and a carry output, with no clock and no state. Its distinguishing feature is how the carries are formed. A ripple chain passes each stage's carry on to the next stage. Here, the carry into every stage is a two-level sum of products built only from the operand bits of the lower stages and the external carry input. Each such expression is obtained by repeatedly substituting the full-adder majority equation `c = ab + ac + bc` into itself until no intermediate carry is left.

The product terms grow with each stage: the carry into stage 1 has 3 terms, stage 2 has 7, stage 3 has 15 and the carry output has 31. The logic depth therefore stays constant, while the area grows quickly with width.

A build parameter can replace the flattened carries with a plain chain of majority cells, so that both builds can be compared. The two builds have the same ports and must give the same result for every input.

Top module: `cla_flat_adder`

## Requirements
- R1: For every one of the 512 combinations of `a`, `b` and `cin`, the 5-bit value `{cout, s}` equals the arithmetic sum `a + b + cin`.
- R2: Sum bit 0 equals `a[0] XOR b[0] XOR cin`.
- R3: The carry into bit 1 (recovered as `s[1] ^ a[1] ^ b[1]`) equals `b[0]·cin + a[0]·cin + a[0]·b[0]`.
- R4: The carry into bit 2 (recovered as `s[2] ^ a[2] ^ b[2]`) equals the seven-term expansion `a1·b1 + b1·b0·cin + b1·a0·cin + b1·a0·b0 + a1·b0·cin + a1·a0·cin + a1·a0·b0`.
- R5: When `a[3]` and `b[3]` are both 1, `cout` is 1 whatever the other inputs are.
- R6: When `a ^ b` is all ones (every bit pair differs), `cout` equals `cin` and `s` is `4'b1111` when `cin` is 0 and `4'b0000` when `cin` is 1.
- R7: The build with `USE_RIPPLE = 1` produces the same `s` and `cout` as the default flattened build for every input combination.
- R8: With `a = 0` and `b = 0`, `s` equals `{3'b000, cin}` and `cout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 4 | First operand |
| b | input | 4 | Second operand |
| cin | input | 1 | Carry into stage 0 |
| s | output | 4 | Sum bits |
| cout | output | 1 | Carry out of stage 3 |

## Verification
Two functions can act on the same input vector. The first is generating a carry in a low stage. The second is carrying it through every higher stage to `cout`. Vectors such as `a = 4'b1111, b = 4'b0001` provoke this, and so does any vector with `a ^ b` all ones and `cin = 1`. The result is judged in two ways: against the arithmetic sum, and by recovering each internal carry from `s ^ a ^ b` and comparing it with the expected expansion. Because the bench sweeps all 512 vectors on both builds, every such coincidence is covered.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned CLA_W = 4;

  // Product-term count of the flattened carry out of stage k
  function automatic int unsigned term_count(input int unsigned k);
    return (2 ** (k + 2)) - 1;
  endfunction
endpackage

// File: rtl/cla_flat_carry.sv
// Flattened carries: carry into stage k+1 is an OR of products built only
// from a[k:0], b[k:0] and cin. Each stage's term set is
//   { a_k&b_k } U { b_k & t : t in prev } U { a_k & t : t in prev }
// which is the full-adder carry ab+ac+bc with c substituted away.
// Stage 1: b0&cin | a0&cin | a0&b0
// Stage 2: a1b1 | b1b0cin | b1a0cin | b1a0b0 | a1b0cin | a1a0cin | a1a0b0
module cla_flat_carry
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH = CLA_W
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH:0]   carry
);
  assign carry[0] = cin;

  for (genvar k = 0; k < WIDTH; k++) begin : g_stg
    localparam int unsigned NT = term_count(k);
    localparam int unsigned NP = (NT - 1) / 2;
    logic [NT-1:0] term;

    if (k == 0) begin : g_first
      assign term[0] = a[0] & b[0];
      assign term[1] = b[0] & cin;
      assign term[2] = a[0] & cin;
    end else begin : g_next
      assign term[0] = a[k] & b[k];
      for (genvar j = 0; j < NP; j++) begin : g_sub
        assign term[1 + j]      = b[k] & g_stg[k-1].term[j];
        assign term[1 + NP + j] = a[k] & g_stg[k-1].term[j];
      end
    end

    assign carry[k+1] = |term;
  end
endmodule

// File: rtl/cla_ripple_carry.sv
// Comparison build: chain of majority cells, one per stage.
module cla_ripple_carry
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH = CLA_W
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH:0]   carry
);
  assign carry[0] = cin;

  for (genvar k = 0; k < WIDTH; k++) begin : g_fa
    assign carry[k+1] = (a[k] & b[k]) | (a[k] & carry[k]) | (b[k] & carry[k]);
  end
endmodule

// File: rtl/cla_sum_xor.sv
module cla_sum_xor
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH = CLA_W
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] cin_vec,
  output logic [WIDTH-1:0] s
);
  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    assign s[k] = a[k] ^ b[k] ^ cin_vec[k];
  end
endmodule

// File: rtl/cla_flat_adder.sv
module cla_flat_adder
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH      = CLA_W,
  parameter bit          USE_RIPPLE = 1'b0
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] s,
  output logic             cout
);
  logic [WIDTH:0] carry;

  if (USE_RIPPLE) begin : g_ripple
    cla_ripple_carry #(.WIDTH(WIDTH)) u_carry (
      .a(a), .b(b), .cin(cin), .carry(carry)
    );
  end else begin : g_flat
    cla_flat_carry #(.WIDTH(WIDTH)) u_carry (
      .a(a), .b(b), .cin(cin), .carry(carry)
    );
  end

  cla_sum_xor #(.WIDTH(WIDTH)) u_sum (
    .a(a), .b(b), .cin_vec(carry[WIDTH-1:0]), .s(s)
  );

  assign cout = carry[WIDTH];
endmodule

// File: rtl/cla_flat_adder_chk.sv
module cla_flat_adder_chk
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH = CLA_W
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] s,
  input logic             cout
);
  logic [WIDTH:0]   total;
  logic [WIDTH-1:0] c_rec;
  logic             maj1;
  logic             exp2;

  always_comb begin
    total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    c_rec = s ^ a ^ b;
    maj1  = (b[0] & cin) | (a[0] & cin) | (a[0] & b[0]);
    exp2  = (a[1] & b[1]) | (b[1] & b[0] & cin) | (b[1] & a[0] & cin)
          | (b[1] & a[0] & b[0]) | (a[1] & b[0] & cin) | (a[1] & a[0] & cin)
          | (a[1] & a[0] & b[0]);
  end

  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      AST_SUM_MATCH:   assert ({cout, s} == total); // R1
      AST_BIT0_SUM:    assert (s[0] == (a[0] ^ b[0] ^ cin)); // R2
      AST_CARRY1_EXP:  assert (c_rec[1] == maj1); // R3
      AST_CARRY2_EXP:  assert (c_rec[2] == exp2); // R4
      AST_TOP_GEN:     assert (!(a[WIDTH-1] & b[WIDTH-1]) || cout); // R5
      AST_FULL_PROP:   assert ((a ^ b) != {WIDTH{1'b1}} || cout == cin); // R6
      AST_ZERO_OPS:    assert ((a | b) != '0 || (cout == 1'b0 && s == {{(WIDTH-1){1'b0}}, cin})); // R8
    end
  end
endmodule

bind cla_flat_adder cla_flat_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a(a), .b(b), .cin(cin), .s(s), .cout(cout)
);

// File: tb/cla_flat_adder_bench.sv
`timescale 1ns/1ps
module cla_flat_adder_bench;
  logic clk;
  logic rst_n;
  logic [3:0] a, b;
  logic       cin;
  logic [3:0] s_f, s_r;
  logic       co_f, co_r;
  int checks;
  int failures;
  bit done;

  typedef struct packed {
    logic [3:0] a;
    logic [3:0] b;
    logic       ci;
    logic [4:0] exp;
  } item_t;
  item_t q[$];

  cla_flat_adder u_cla_flat_adder (
    .a(a), .b(b), .cin(cin), .s(s_f), .cout(co_f)
  );
  cla_flat_adder #(.USE_RIPPLE(1'b1)) u_cla_flat_adder_ripple (
    .a(a), .b(b), .cin(cin), .s(s_r), .cout(co_r)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s a=%h b=%h cin=%b actual=%0h expected=%0h", tag, a, b, cin, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] av, input logic [3:0] bv, input logic cv);
    item_t it;
    @(posedge clk);
    a = av; b = bv; cin = cv;
    it.a = av; it.b = bv; it.ci = cv;
    it.exp = 5'(av) + 5'(bv) + 5'(cv);
    q.push_back(it);
  endtask

  // Monitor: compares away from the rising edge
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t it;
      int c1, c2;
      it = q.pop_front();
      check({co_f, s_f} == it.exp, "R1 flat sum", {co_f, s_f}, it.exp);
      check({co_r, s_r} == {co_f, s_f}, "R7 ripple vs flat", {co_r, s_r}, {co_f, s_f});
      check(s_f[0] == (it.a[0] ^ it.b[0] ^ it.ci), "R2 bit0", s_f[0], it.a[0] ^ it.b[0] ^ it.ci);
      c1 = (int'(it.a[0]) + int'(it.b[0]) + int'(it.ci)) / 2;
      check(int'(s_f[1] ^ it.a[1] ^ it.b[1]) == c1, "R3 carry1", s_f[1] ^ it.a[1] ^ it.b[1], c1);
      c2 = (int'(it.a[1:0]) + int'(it.b[1:0]) + int'(it.ci)) / 4;
      check(int'(s_f[2] ^ it.a[2] ^ it.b[2]) == c2, "R4 carry2", s_f[2] ^ it.a[2] ^ it.b[2], c2);
      if (it.a[3] & it.b[3])
        check(co_f == 1'b1, "R5 top generate", co_f, 1);
      if ((it.a ^ it.b) == 4'hF) begin
        check(co_f == it.ci, "R6 full propagate cout", co_f, it.ci);
        check(s_f == (it.ci ? 4'h0 : 4'hF), "R6 full propagate sum", s_f, it.ci ? 0 : 15);
      end
      if (it.a == 4'h0 && it.b == 4'h0)
        check(s_f == {3'b000, it.ci} && co_f == 1'b0, "R8 zero operands", {co_f, s_f}, it.ci);
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({co_f, s_f} == 5'd0, "R8 reset state", {co_f, s_f}, 0);
    rst_n = 1'b1;
    // Directed corner: low generate carried through every stage
    drive(4'hF, 4'h1, 1'b0);
    drive(4'hA, 4'h5, 1'b1);
    drive(4'h8, 4'h8, 1'b0);
    // Exhaustive sweep, R1 and R7 over all 512 vectors
    for (int i = 0; i < 512; i++)
      drive(i[3:0], i[7:4], i[8]);
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule